// File: doc/BRIEF.md
# Latching Extender-Sublayer Status Register Bank

This block is the read-only status side of a 10-gigabit extender-sublayer management device. Management logic reads it through a register port made of an address, a read strobe and 16-bit read data. The block watches a set of live conditions:

- link up
- transmit fault
- receive fault
- per-lane synchronisation for four lanes
- lane alignment
- a configuration strap that chooses between the terminal-side role and the line-side role

It keeps sticky copies of the link and fault conditions, so that a short event is still visible at the next read. The fixed capability and identity words are produced from constants and the strap.

The link bit latches low and the two fault bits latch high. Reading a register returns its latched state, and after the read that latch reloads from the live input. An event that occurs in the same cycle as the read is carried into the reloaded state, so it is not lost. A summary bit in status register 1 reports the OR of the two latched fault bits held in status register 8.

Top module: `statusBankTop`

## Requirements
- R1: After reset the read data is 0x0000, the link latch holds "down" and both fault latches are clear.
- R2: Register 8 bit 11 (transmit fault) becomes 1 in the cycle after `txFault` is seen. It stays 1 until register 8 is read.
- R3: Register 8 bit 10 (receive fault) becomes 1 in the cycle after `rxFault` is seen. It stays 1 until register 8 is read.
- R4: Register 1 bit 2 (link status, 1 = up) becomes 0 after `linkUp` is low in any cycle. It stays 0 until register 1 is read.
- R5: A read returns the latched value as it was in the strobe cycle. The latch then reloads from the live input of that same cycle, so an event that coincides with the read is reported at the next read.
- R6: Register 1 bit 7 reads as the OR of the transmit and receive fault latches.
- R7: Register 8 bits 15:14 read as binary 10.
- R8: Register 4 reads as 0x0001.
- R9: In register 5, bit 5 equals `roleDte`, bit 4 is its complement, bit 0 is 1, and every other bit is 0.
- R10: In register 24, bit 12 is `laneAligned` and bits 3:0 are `laneSync[3:0]` (lane D down to lane A). Both are sampled in the strobe cycle.
- R11: Reserved bits in every register read 0. Any address other than 1, 4, 5, 8 and 24 reads 0x0000.
- R12: `rdData` takes the selected value one cycle after a strobe and holds it while `rdStrobe` is low.
- R13: Reading register 1 does not change the fault latches. Reading register 8 does not change the link latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddr | input | 16 | Register number to read |
| rdStrobe | input | 1 | Read request, one cycle per read |
| rdData | output | 16 | Registered read data |
| linkUp | input | 1 | Live link state, 1 = up |
| txFault | input | 1 | Live transmit fault |
| rxFault | input | 1 | Live receive fault |
| laneSync | input | 4 | Live per-lane sync, bit 0 = lane A |
| laneAligned | input | 1 | Live lane alignment |
| roleDte | input | 1 | Strap, 1 = terminal-side role, 0 = line-side role |

## Verification
The properties assume that `rdAddr` and the live status inputs are steady around each rising edge and are driven to known values from reset onward. They also assume that `rdStrobe` lasts a single cycle per read, although back-to-back strobes are legal. The stimulus changes every input only on the falling edge. It mixes single-cycle fault pulses, link drops and reads that land on the same cycle as an event. Addresses are drawn from the five mapped registers plus a few unmapped numbers next to them.

// File: rtl/statusPkg.sv
package statusPkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] ADR_STAT1 = 16'd1;
  localparam logic [ADDR_W-1:0] ADR_SPEED = 16'd4;
  localparam logic [ADDR_W-1:0] ADR_PKG   = 16'd5;
  localparam logic [ADDR_W-1:0] ADR_STAT2 = 16'd8;
  localparam logic [ADDR_W-1:0] ADR_LANE  = 16'd24;

  localparam int BIT_LOCFLT = 7;
  localparam int BIT_LINK   = 2;
  localparam int BIT_TXF    = 11;
  localparam int BIT_RXF    = 10;
  localparam int BIT_ALIGN  = 12;
  localparam int BIT_DTE    = 5;
  localparam int BIT_PHYR   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT1,
    SEL_SPEED,
    SEL_PKG,
    SEL_STAT2,
    SEL_LANE
  } regSelE;

  typedef struct packed {
    logic   rdEn;
    regSelE sel;
    logic   clrLink;
    logic   clrFault;
  } ctrlStrobeT;
endpackage

// File: rtl/statusCtrl.sv
module statusCtrl
  import statusPkg::*;
(
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdStrobe,
  output ctrlStrobeT        strobe
);
  regSelE selNext;

  always_comb begin
    unique case (rdAddr)
      ADR_STAT1: selNext = SEL_STAT1;
      ADR_SPEED: selNext = SEL_SPEED;
      ADR_PKG:   selNext = SEL_PKG;
      ADR_STAT2: selNext = SEL_STAT2;
      ADR_LANE:  selNext = SEL_LANE;
      default:   selNext = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.rdEn     = rdStrobe;
    strobe.sel      = selNext;
    strobe.clrLink  = rdStrobe && (selNext == SEL_STAT1);
    strobe.clrFault = rdStrobe && (selNext == SEL_STAT2);
  end
endmodule

// File: rtl/statusData.sv
module statusData
  import statusPkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic             linkUp,
  input  logic             txFault,
  input  logic             rxFault,
  input  logic [LANES-1:0] laneSync,
  input  logic             laneAligned,
  input  logic             roleDte,
  output logic [REG_W-1:0] rdData,
  output logic             linkLatch,
  output logic             txLatch,
  output logic             rxLatch
);
  localparam int NFLT = 2;

  logic [NFLT-1:0] faultLive;
  logic            faultLat [NFLT];
  logic [REG_W-1:0] muxData;

  assign faultLive = {txFault, rxFault};

  // Latch-high fault bits: reload from live on read, else accumulate
  for (genvar g = 0; g < NFLT; g++) begin : gFault
    always_ff @(posedge clk) begin
      if (!rstN)                faultLat[g] <= 1'b0;
      else if (strobe.clrFault) faultLat[g] <= faultLive[g];
      else                      faultLat[g] <= faultLat[g] | faultLive[g];
    end
  end

  assign txLatch = faultLat[1];
  assign rxLatch = faultLat[0];

  // Latch-low link bit
  always_ff @(posedge clk) begin
    if (!rstN)               linkLatch <= 1'b0;
    else if (strobe.clrLink) linkLatch <= linkUp;
    else                     linkLatch <= linkLatch & linkUp;
  end

  always_comb begin
    muxData = '0;
    unique case (strobe.sel)
      SEL_STAT1: begin
        muxData[BIT_LOCFLT] = txLatch | rxLatch;
        muxData[BIT_LINK]   = linkLatch;
      end
      SEL_SPEED: muxData[0] = 1'b1;
      SEL_PKG: begin
        muxData[BIT_DTE]  = roleDte;
        muxData[BIT_PHYR] = ~roleDte;
        muxData[0]        = 1'b1;
      end
      SEL_STAT2: begin
        muxData[15:14]   = 2'b10;
        muxData[BIT_TXF] = txLatch;
        muxData[BIT_RXF] = rxLatch;
      end
      SEL_LANE: begin
        muxData[BIT_ALIGN]   = laneAligned;
        muxData[LANES-1:0]   = laneSync;
      end
      default: muxData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= muxData;
  end
endmodule

// File: rtl/statusBankTop.sv
module statusBankTop
  import statusPkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdStrobe,
  output logic [REG_W-1:0]  rdData,
  input  logic              linkUp,
  input  logic              txFault,
  input  logic              rxFault,
  input  logic [LANES-1:0]  laneSync,
  input  logic              laneAligned,
  input  logic              roleDte
);
  ctrlStrobeT strobe;
  logic linkLatch;
  logic txLatch;
  logic rxLatch;

  statusCtrl uCtrl (
    .rdAddr  (rdAddr),
    .rdStrobe(rdStrobe),
    .strobe  (strobe)
  );

  statusData #(.LANES(LANES)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .linkUp     (linkUp),
    .txFault    (txFault),
    .rxFault    (rxFault),
    .laneSync   (laneSync),
    .laneAligned(laneAligned),
    .roleDte    (roleDte),
    .rdData     (rdData),
    .linkLatch  (linkLatch),
    .txLatch    (txLatch),
    .rxLatch    (rxLatch)
  );
endmodule

// File: rtl/statusBankChk.sv
module statusBankChk
  import statusPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdStrobe,
  input logic [REG_W-1:0]  rdData,
  input logic              linkUp,
  input logic              txFault,
  input logic              rxFault,
  input logic              linkLatch,
  input logic              txLatch,
  input logic              rxLatch
);
  AST_TX_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    txFault |=> txLatch); // R2
  AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rxFault |=> rxLatch); // R3
  AST_LINK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> !linkLatch); // R4
  AST_READ_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == ADR_STAT2) |=>
      (rdData[11] == $past(txLatch)) && (rdData[10] == $past(rxLatch))); // R5
  AST_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == ADR_STAT1) |=>
      (rdData[7] == ($past(txLatch) | $past(rxLatch)))); // R6
  AST_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == ADR_STAT2) |=> (rdData[15:14] == 2'b10)); // R7
  AST_SPEED_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == ADR_SPEED) |=> (rdData == 16'h0001)); // R8
  AST_ROLE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == ADR_PKG) |=> (rdData[5] != rdData[4])); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr != ADR_STAT1 && rdAddr != ADR_SPEED && rdAddr != ADR_PKG
     && rdAddr != ADR_STAT2 && rdAddr != ADR_LANE) |=> (rdData == 16'h0000)); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData)); // R12
  AST_LINK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == ADR_STAT2 && !linkLatch) |=> !linkLatch); // R13
endmodule

bind statusBankTop statusBankChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .rdAddr   (rdAddr),
  .rdStrobe (rdStrobe),
  .rdData   (rdData),
  .linkUp   (linkUp),
  .txFault  (txFault),
  .rxFault  (rxFault),
  .linkLatch(linkLatch),
  .txLatch  (txLatch),
  .rxLatch  (rxLatch)
);

// File: tb/statusBankTop_test.sv
module statusBankTop_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] rdAddr = '0;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdData;
  logic        linkUp = 1'b1;
  logic        txFault = 1'b0;
  logic        rxFault = 1'b0;
  logic [3:0]  laneSync = 4'hF;
  logic        laneAligned = 1'b1;
  logic        roleDte = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit mLink = 0;
  bit mTx = 0;
  bit mRx = 0;
  logic [15:0] expData = '0;

  always #(CLK_P/2) clk = ~clk;

  statusBankTop uut (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdStrobe(rdStrobe), .rdData(rdData),
    .linkUp(linkUp), .txFault(txFault), .rxFault(rxFault), .laneSync(laneSync),
    .laneAligned(laneAligned), .roleDte(roleDte)
  );

  function automatic logic [15:0] modelRead(input logic [15:0] a);
    logic [15:0] v = '0;
    case (a)
      16'd1:  begin v[7] = mTx | mRx; v[2] = mLink; end
      16'd4:  v = 16'h0001;
      16'd5:  begin v[5] = roleDte; v[4] = !roleDte; v[0] = 1'b1; end
      16'd8:  begin v[15] = 1'b1; v[11] = mTx; v[10] = mRx; end
      16'd24: begin v[12] = laneAligned; v[3:0] = laneSync; end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tagOf(input logic [15:0] a, input logic s);
    if (!s) return "R12";
    case (a)
      16'd1:  return "R4 R6";
      16'd4:  return "R8";
      16'd5:  return "R9";
      16'd8:  return "R2 R3 R7";
      16'd24: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdData actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs applied now (falling edge), checked at next falling edge
  task automatic tick(input logic [15:0] a, input logic s, input string note);
    string tag;
    rdAddr = a;
    rdStrobe = s;
    if (s) expData = modelRead(a);
    if (s && a == 16'd1) mLink = linkUp;
    else                 mLink = mLink & linkUp;
    if (s && a == 16'd8) begin mTx = txFault; mRx = rxFault; end
    else begin mTx = mTx | txFault; mRx = mRx | rxFault; end
    tag = {tagOf(a, s), note};
    @(posedge clk);
    @(negedge clk);
    check(rdData, expData, tag);
  endtask

  task automatic setLive(input bit l, input bit t, input bit r);
    linkUp = l; txFault = t; rxFault = r;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL all requirements: watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [10] = '{16'd1, 16'd4, 16'd5, 16'd8, 16'd24, 16'd0, 16'd3, 16'd9, 16'd25, 16'd200};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(rdData, 16'h0000, "R1 reset data");
    // R1: link latch starts down, faults clear
    setLive(1, 0, 0);
    tick(16'd1, 1, " R1 link down after reset");
    check(rdData, 16'h0000, "R1 first status read");
    tick(16'd8, 1, " R1 faults clear");
    check(rdData, 16'h8000, "R1 R7 status2 after reset");
    tick(16'd1, 1, " R4 reload up");
    check(rdData, 16'h0004, "R4 link up after reload");
    // R4: short link drop is held low
    setLive(0, 0, 0); tick(16'd0, 0, " R4 drop");
    setLive(1, 0, 0); tick(16'd0, 0, " R4 restore");
    tick(16'd1, 1, " R4 held low");
    check(rdData, 16'h0000, "R4 latched low");
    tick(16'd1, 1, " R4 cleared by read");
    check(rdData, 16'h0004, "R4 up again");
    // R2/R3: fault pulses, then R6 summary and R13 no clear by reg 1
    setLive(1, 1, 0); tick(16'd0, 0, " R2 pulse");
    setLive(1, 0, 0); tick(16'd1, 1, " R6 R13 summary");
    check(rdData, 16'h0084, "R6 summary from tx fault");
    tick(16'd8, 1, " R13 tx still latched");
    check(rdData, 16'h8800, "R2 R13 tx latched");
    tick(16'd8, 1, " R2 cleared");
    check(rdData, 16'h8000, "R2 cleared by read");
    setLive(1, 0, 1); tick(16'd0, 0, " R3 pulse");
    setLive(1, 0, 0); tick(16'd8, 1, " R3 latched");
    check(rdData, 16'h8400, "R3 rx latched");
    // R5: event in the read cycle kept for the next read
    setLive(1, 1, 1); tick(16'd8, 1, " R5 coincident");
    check(rdData, 16'h8000, "R5 read returns old latch");
    setLive(1, 0, 0); tick(16'd8, 1, " R5 kept");
    check(rdData, 16'h8C00, "R5 coincident event kept");
    setLive(0, 0, 0); tick(16'd1, 1, " R5 link coincident");
    setLive(1, 0, 0); tick(16'd1, 1, " R5 link kept");
    check(rdData, 16'h0000, "R5 coincident link drop kept");
    // R9, R8, R10, R11
    roleDte = 1'b1; tick(16'd5, 1, "");
    check(rdData, 16'h0021, "R9 dte strap");
    roleDte = 1'b0; tick(16'd5, 1, "");
    check(rdData, 16'h0011, "R9 phy strap");
    tick(16'd4, 1, "");
    laneSync = 4'b1010; laneAligned = 1'b0; tick(16'd24, 1, "");
    check(rdData, 16'h000A, "R10 lane pattern");
    laneSync = 4'b0101; laneAligned = 1'b1; tick(16'd24, 1, "");
    check(rdData, 16'h1005, "R10 aligned pattern");
    tick(16'd2, 1, "");
    check(rdData, 16'h0000, "R11 unmapped");
    laneSync = 4'hF; tick(16'd0, 0, " R12 hold");
    check(rdData, 16'h0000, "R12 hold");
    // mixed stimulus, compared with the model every clock
    for (int i = 0; i < 3000; i++) begin
      linkUp      = ($urandom_range(0, 15) != 0);
      txFault     = ($urandom_range(0, 19) == 0);
      rxFault     = ($urandom_range(0, 19) == 0);
      laneSync    = 4'($urandom_range(0, 15));
      laneAligned = 1'($urandom_range(0, 1));
      roleDte     = 1'($urandom_range(0, 1));
      tick(addrs[$urandom_range(0, 9)], ($urandom_range(0, 2) != 0), " mixed");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule